// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets a host controller on a two-wire serial bus read and write a small file of 8-bit registers. It watches the bus lines on its own system clock and answers only to its own 7-bit address. The lowest address bit comes from a strap pin, so two of these blocks can share one bus. After the address byte, the first byte a writer sends is a register index. Every later byte is stored at that index, and the index then steps up by one. A reader first sets the index with a write, then sends a repeated start and the read address. The block then sends register contents from that index upward until the host declines a byte.

The block reacts in defined ways to misuse:
- An index outside the map is refused with a not-acknowledge, and the block goes idle.
- A write burst that runs past the last register loses the extra byte, is refused, and the block goes idle.
- A read burst that runs past the last register keeps returning the last register.
- A start or stop condition in the middle of a byte ends the transfer at once.

The block drives the data line only low. Its drive is shown as a constant-low data output plus an output enable. The register contents are available in parallel to the surrounding logic. One register mirrors a status input and cannot be written. One register can be written but reads back as zero.

Top module: `i2cr_slave`

## Requirements
- R1: The 8-bit write address is 0xD4 when `addr_strap` is 0 and 0xD6 when it is 1. The read address is the write address plus one, where bit 0 = 1 means read. On a match the block pulls SDA low during the ninth clock. Any other address gets no acknowledge, and the block ignores the rest of the transfer.
- R2: Bytes move most significant bit first in both directions. The slave changes SDA only after SCL falls or after a start or stop condition.
- R3: The byte after a write address is the register index. An index of 0x00 to 0x07 is acknowledged and loaded as the pointer. An index of 0x08 or above gets no acknowledge, and later bytes in that transfer are also refused.
- R4: In a write burst, each data byte is stored at the pointer and acknowledged, and the pointer then steps up by one. Register i appears on `reg_q[8i+7:8i]`.
- R5: A write byte that arrives when the pointer has passed 0x07 is not stored. It gets no acknowledge, and the block goes idle.
- R6: A read is a write of the index, a repeated start, and the read address. The block acknowledges the read address and sends the register at the pointer. The pointer steps up after each byte the host acknowledges. A host not-acknowledge ends the burst.
- R7: A read burst that passes register 0x07 returns register 0x07 again for every further byte until the host sends a not-acknowledge.
- R8: A stop condition at any bit ends the transfer with no write. A start condition at any bit begins a fresh address phase.
- R9: After reset, register 0x00 holds 0x12, every other register holds 0x00, and SDA is released.
- R10: Register 0x06 is read-only. Writes to it are acknowledged but change nothing, its `reg_q` byte stays 0x00, and a read returns `status_in`.
- R11: Register 0x05 is write-only. Writes to it are stored and shown on `reg_q`, and a read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA drive value, always 0 |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| addr_strap | input | 1 | Selects bit 1 of the 8-bit device address |
| status_in | input | 8 | Value returned when register 0x06 is read |
| reg_q | output | 64 | All register contents; byte i is register i |

## Verification
A line change reaches the logic after the two synchroniser flops and one edge register. An SCL fall therefore moves `sda_oe` about four system clocks later. A write lands on `reg_q` in that same cycle, following the fall after the eighth bit. The bench holds each SCL half-period for 16 clocks. It changes SDA 8 clocks into the low phase and samples SDA 8 clocks into the high phase, so every acknowledge and read bit is read long after it is due. A behavioural register model, updated at the ninth high phase of each byte, is compared with `reg_q` on every clock of the quiet window after each stop. Mid-transfer, `reg_q` may lag the model by a few clocks, so no comparison is made there.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WDATA,
    PH_ACK,
    PH_RDATA,
    PH_RACK
  } phase_e;
endpackage

// File: rtl/i2cr_pinsync.sv
module i2cr_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic rise_evt,
  output logic fall_evt,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign rise_evt  = scl_s & ~scl_d;
  assign fall_evt  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile #(
  parameter int         NUM_REGS = 8,
  parameter int         RO_IDX   = 6,
  parameter int         WO_IDX   = 5,
  parameter logic [7:0] RST0     = 8'h12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  output logic [7:0]            rd_data,
  input  logic [7:0]            status_in,
  output logic [NUM_REGS*8-1:0] reg_q
);
  localparam int              IDXW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0]      LIMIT   = 9'(NUM_REGS);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NUM_REGS - 1);

  logic [7:0]      val [NUM_REGS];
  logic [IDXW-1:0] rd_sel;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
    if (gi == RO_IDX) begin : g_ro
      assign val[gi]           = status_in;
      assign reg_q[gi*8 +: 8]  = 8'h00;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              q <= (gi == 0) ? RST0 : 8'h00;
        else if (wr_en && wr_addr == 8'(gi))     q <= wr_data;
      end
      assign reg_q[gi*8 +: 8] = q;
      assign val[gi]          = (gi == WO_IDX) ? 8'h00 : q;
    end
  end

  assign rd_sel  = ({1'b0, rd_addr} < LIMIT) ? rd_addr[IDXW-1:0] : TOP_IDX;
  assign rd_data = val[rd_sel];

  // R5: a store is only ever issued inside the map
  p_wr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < LIMIT));
endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto
  import i2cr_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [5:0] DEV_HI   = 6'b110101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       strap,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  localparam logic [8:0] LIMIT = 9'(NUM_REGS);
  localparam logic [7:0] TOP   = 8'(NUM_REGS - 1);

  phase_e     state_q, next_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       byte_end, addr_hit, sub_ok, ptr_ok;

  always_comb begin
    byte_end = fall_evt && (cnt_q == 4'd8);
    addr_hit = (rx_q[7:1] == {DEV_HI, strap});
    sub_ok   = ({1'b0, rx_q} < LIMIT);
    ptr_ok   = ({1'b0, ptr_q} < LIMIT);
  end

  assign wr_en   = (state_q == PH_WDATA) && byte_end && ptr_ok && !start_evt && !stop_evt;
  assign wr_addr = ptr_q;
  assign wr_data = rx_q;
  assign rd_addr = ptr_q;
  assign sda_oe  = (state_q == PH_ACK) || ((state_q == PH_RDATA) && !tx_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      next_q  <= PH_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      ptr_q   <= '0;
    end else if (start_evt) begin
      state_q <= PH_ADDR;
      cnt_q   <= '0;
    end else if (stop_evt) begin
      state_q <= PH_IDLE;
    end else begin
      case (state_q)
        PH_ADDR, PH_SUB, PH_WDATA: begin
          if (rise_evt && cnt_q != 4'd8) begin
            rx_q  <= {rx_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_end) begin
            cnt_q <= '0;
            if (state_q == PH_ADDR) begin
              if (addr_hit) begin
                state_q <= PH_ACK;
                next_q  <= rx_q[0] ? PH_RDATA : PH_SUB;
              end else state_q <= PH_IDLE;
            end else if (state_q == PH_SUB) begin
              if (sub_ok) begin
                ptr_q   <= rx_q;
                state_q <= PH_ACK;
                next_q  <= PH_WDATA;
              end else state_q <= PH_IDLE;
            end else begin
              if (ptr_ok) begin
                ptr_q   <= ptr_q + 8'd1;
                state_q <= PH_ACK;
                next_q  <= PH_WDATA;
              end else state_q <= PH_IDLE;
            end
          end
        end
        PH_ACK: if (fall_evt) begin
          state_q <= next_q;
          cnt_q   <= '0;
          tx_q    <= rd_data;
        end
        PH_RDATA: begin
          if (rise_evt) cnt_q <= cnt_q + 4'd1;
          if (fall_evt) begin
            if (cnt_q == 4'd8) begin
              state_q <= PH_RACK;
              cnt_q   <= '0;
            end else tx_q <= {tx_q[6:0], 1'b0};
          end
        end
        PH_RACK: begin
          if (rise_evt) begin
            if (sda_s) state_q <= PH_IDLE;
            else if ({1'b0, ptr_q} < LIMIT - 9'd1) ptr_q <= ptr_q + 8'd1;
            else ptr_q <= TOP;
          end
          if (fall_evt) begin
            state_q <= PH_RDATA;
            tx_q    <= rd_data;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: the slave's drive moves only after an SCL fall or a bus condition
  p_oe_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(fall_evt || start_evt || stop_evt));
  // R8: a stop releases the line and parks the block
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && state_q == PH_IDLE));
  // R8: a start always begins with the line released
  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
  // R4: auto-increment never runs more than one step past the map
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ptr_q} <= LIMIT);
endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave #(
  parameter int         NUM_REGS = 8,
  parameter int         RO_IDX   = 6,
  parameter int         WO_IDX   = 5,
  parameter logic [7:0] RST0     = 8'h12,
  parameter logic [5:0] DEV_HI   = 6'b110101,
  parameter int         STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_o,
  output logic                  sda_oe,
  input  logic                  addr_strap,
  input  logic [7:0]            status_in,
  output logic [NUM_REGS*8-1:0] reg_q
);
  logic       sda_s, rise_evt, fall_evt, start_evt, stop_evt;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  i2cr_pinsync #(.STAGES(STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s,
    .rise_evt, .fall_evt, .start_evt, .stop_evt
  );

  i2cr_proto #(.NUM_REGS(NUM_REGS), .DEV_HI(DEV_HI)) u_proto (
    .clk, .rst_n, .sda_s, .rise_evt, .fall_evt, .start_evt, .stop_evt,
    .strap(addr_strap), .rd_data, .rd_addr, .wr_en, .wr_addr, .wr_data, .sda_oe
  );

  i2cr_regfile #(.NUM_REGS(NUM_REGS), .RO_IDX(RO_IDX), .WO_IDX(WO_IDX), .RST0(RST0)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .status_in, .reg_q
  );

  assign sda_o = 1'b0;
endmodule

// File: tb/i2cr_slave_bench.sv
module i2cr_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_o, sda_oe;
  logic [63:0] reg_q;
  logic [7:0] status = 8'hA5;
  wire sda_line = sda_m & ~(sda_oe & ~sda_o);

  i2cr_slave u_i2cr_slave (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_o, .sda_oe,
    .addr_strap(strap), .status_in(status), .reg_q
  );

  int checks = 0, errors = 0;
  int mdl [8];
  bit cmp_en = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the register model in quiet windows
  always @(negedge clk) if (cmp_en) begin
    for (int i = 0; i < 8; i++) begin
      checks++;
      if (reg_q[i*8 +: 8] !== 8'(mdl[i])) begin
        errors++;
        $display("FAIL R4 R10 R11 reg %0d actual %0h expected %0h", i, reg_q[i*8 +: 8], mdl[i]);
      end
    end
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic settle(); cmp_en = 1'b1; repeat (24) @(negedge clk); cmp_en = 1'b0; endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    hq(); sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      hq(); sda_m = b[7-i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    hq(); sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); ack = ~sda_line; hq(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq(); hq(); scl_m = 1'b1; hq(); d[7-i] = sda_line; hq(); scl_m = 1'b0;
    end
    hq(); sda_m = mack ? 1'b0 : 1'b1; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0;
    hq(); sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) mdl[i] = 0;
    mdl[0] = 8'h12;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 sda released", int'(sda_oe), 0);
    for (int i = 0; i < 8; i++) chk("R9 reset value", int'(reg_q[i*8 +: 8]), mdl[i]);
    settle();

    // R1: foreign address is refused
    bus_start(); send_byte(8'hD6, a); chk("R1 wrong address nack", int'(a), 0);
    send_byte(8'h01, a); chk("R1 ignored after nack", int'(a), 0);
    bus_stop(); settle();

    // R4: write burst with auto-increment
    bus_start(); send_byte(8'hD4, a); chk("R1 own address ack", int'(a), 1);
    send_byte(8'h01, a); chk("R3 index ack", int'(a), 1);
    send_byte(8'h11, a); chk("R4 data ack", int'(a), 1); mdl[1] = 8'h11;
    send_byte(8'h22, a); chk("R4 data ack", int'(a), 1); mdl[2] = 8'h22;
    send_byte(8'h33, a); chk("R4 data ack", int'(a), 1); mdl[3] = 8'h33;
    bus_stop(); settle();

    // R6: read via repeated start, MSB first (R2)
    bus_start(); send_byte(8'hD4, a); send_byte(8'h01, a);
    bus_start(); send_byte(8'hD5, a); chk("R6 read address ack", int'(a), 1);
    recv_byte(d, 1'b1); chk("R2 R6 read byte", int'(d), 8'h11);
    recv_byte(d, 1'b1); chk("R6 read byte", int'(d), 8'h22);
    recv_byte(d, 1'b0); chk("R6 read byte", int'(d), 8'h33);
    chk("R6 released after host nack", int'(sda_oe), 0);
    bus_stop(); settle();

    // R11 write-only, R10 read-only, R5 write overrun
    bus_start(); send_byte(8'hD4, a); send_byte(8'h05, a);
    send_byte(8'h5A, a); chk("R11 write ack", int'(a), 1); mdl[5] = 8'h5A;
    send_byte(8'h77, a); chk("R10 read-only write ack", int'(a), 1);
    send_byte(8'h99, a); chk("R4 top write ack", int'(a), 1); mdl[7] = 8'h99;
    send_byte(8'hF0, a); chk("R5 overrun nack", int'(a), 0);
    bus_stop(); settle();

    // R7 read overrun, R10, R11 read values
    bus_start(); send_byte(8'hD4, a); send_byte(8'h04, a);
    bus_start(); send_byte(8'hD5, a);
    recv_byte(d, 1'b1); chk("R6 reg4", int'(d), 0);
    recv_byte(d, 1'b1); chk("R11 write-only reads zero", int'(d), 0);
    recv_byte(d, 1'b1); chk("R10 read-only shows status", int'(d), 8'hA5);
    recv_byte(d, 1'b1); chk("R7 top", int'(d), 8'h99);
    recv_byte(d, 1'b1); chk("R7 top repeated", int'(d), 8'h99);
    recv_byte(d, 1'b0); chk("R7 top repeated", int'(d), 8'h99);
    bus_stop(); settle();

    // R3: index out of range
    bus_start(); send_byte(8'hD4, a); send_byte(8'h08, a);
    chk("R3 invalid index nack", int'(a), 0);
    send_byte(8'h66, a); chk("R3 idle after invalid index", int'(a), 0);
    bus_stop(); settle();

    // R8: stop in mid-byte, then start in mid-byte
    bus_start(); send_byte(8'hD4, a); send_byte(8'h02, a);
    send_bits(8'hFF, 4); bus_stop(); settle();
    bus_start(); send_byte(8'hD4, a); send_byte(8'h03, a);
    send_bits(8'h00, 3);
    bus_start(); send_byte(8'hD4, a); chk("R8 fresh address after start", int'(a), 1);
    send_byte(8'h03, a); send_byte(8'h44, a); chk("R8 write after restart", int'(a), 1);
    mdl[3] = 8'h44;
    bus_stop(); settle();

    // R1: strap selects the other address
    strap = 1'b1; hq();
    bus_start(); send_byte(8'hD4, a); chk("R1 strap1 old address nack", int'(a), 0);
    bus_stop();
    bus_start(); send_byte(8'hD6, a); chk("R1 strap1 address ack", int'(a), 1);
    send_byte(8'h00, a); send_byte(8'h3C, a); mdl[0] = 8'h3C;
    bus_start(); send_byte(8'hD7, a); chk("R1 strap1 read address ack", int'(a), 1);
    send_byte(8'h00, a);
    bus_stop();
    bus_start(); send_byte(8'hD6, a); send_byte(8'h00, a);
    bus_start(); send_byte(8'hD7, a);
    recv_byte(d, 1'b0); chk("R1 strap1 read back", int'(d), 8'h3C);
    bus_stop(); settle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule